// File: doc/BRIEF.md
# Shader Program Command Loader

This block sits on a 32-bit command stream and picks out pixel-shader program packets. A packet opens with one header word that identifies it and gives its length. The payload that follows is cut into instructions of exactly three words each. Every instruction is written as one 96-bit entry into an external program memory. The memory address is the instruction's position in the packet, counted from zero.

While it loads, the block checks each instruction. It looks at the opcode range, the destination register of arithmetic and texture instructions, and the register, channel mask and reserved words of declarations. It holds any violation until the packet ends. On the cycle after the last payload word it pulses a completion strobe with the instruction count and the error flags. A header word that does not match is dropped and flagged. A header whose length is illegal causes its payload to be skipped without any write.

Top module: `shader_loader`

## Requirements
- R1: While `rst_n` is low, every output except `in_ready` is zero.
- R2: A word accepted while idle is a header only if bits 31:29 are 3'b011, bits 28:24 are 5'h1D and bits 23:16 are 8'h05. Any other word is dropped. In that case `hdr_drop` is high for the one cycle after the word and nothing is written.
- R3: The payload length is header bits 15:0 plus one. When that length is not a multiple of three or exceeds 369 words (123 instructions), the payload words are still consumed but nothing is written. In that case `done` reports `err_len`=1 with a count of zero and the other flags at zero.
- R4: `in_ready` is high whenever `rst_n` is high, and only words with `in_valid` high are taken.
- R5: Each group of three payload words forms one instruction. The first word lands in `prog_data` bits 31:0, the second in bits 63:32 and the third in bits 95:64. `prog_we` is high for the one cycle after the third word. `prog_addr` counts 0, 1, 2 and so on within the packet.
- R6: `done` is high for the one cycle after the last payload word, and `done_count` then gives the number of instructions written.
- R7: An opcode (first-word bits 31:24) above 8'h19 sets `err_opcode` at `done`. The instruction is still written.
- R8: For an opcode below 8'h19, the destination type is first-word bits 21:19 and the destination number is bits 17:14. Type 0 is legal with any number. Types 4 and 5 are legal only with number 0. Type 6 is legal only with numbers 0 to 2. Any other type sets `err_field`.
- R9: For opcode 8'h19, the type is bits 21:19, the number is bits 17:14 and the channel mask is bits 13:10. Type 1 needs a number of at most 10 and a mask of 1, 3, 7, 8 or 15. Type 3 needs a mask of 0 and the second and third words both zero. Any other case sets `err_field`.
- R10: The error flags and the count cover only the packet just reported. They are cleared when a new header is taken, and the reported values stay steady until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command word present |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Word accepted when high together with in_valid |
| prog_we | output | 1 | Program memory write strobe |
| prog_addr | output | 7 | Instruction index within the packet |
| prog_data | output | 96 | Three-word instruction, first word lowest |
| done | output | 1 | Packet finished strobe |
| done_count | output | 7 | Instructions written in the last packet |
| err_len | output | 1 | Last packet had an illegal length |
| err_opcode | output | 1 | Last packet held an undefined opcode |
| err_field | output | 1 | Last packet held an illegal register field |
| hdr_drop | output | 1 | A non-matching header word was dropped |

## Verification
A slip in the word-within-instruction position or the remaining-word count shows at the ports at the next write. It appears as a write strobe one or two cycles off, as scrambled word order in `prog_data`, or as `done` missing or early at the end of the packet. A stale error bit or a stale sampler-declaration marker surfaces only at `done`, as a wrong flag. Packets with exactly one fault each, followed by a clean packet, are used so that a leaking flag is caught within one packet. A bad length decode shows as writes during a skipped packet, or as the next header being taken for payload, which shows up as misplaced drops.

// File: rtl/shader_loader.sv
module shader_loader #(
  parameter int MAX_INSTR = 123,
  parameter int LEN_W     = 16,
  localparam int ADDR_W   = $clog2(MAX_INSTR),
  localparam int CNT_W    = $clog2(MAX_INSTR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       in_data,
  output logic              in_ready,
  output logic              prog_we,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [95:0]       prog_data,
  output logic              done,
  output logic [CNT_W-1:0]  done_count,
  output logic              err_len,
  output logic              err_opcode,
  output logic              err_field,
  output logic              hdr_drop
);

  localparam logic [LEN_W:0] MAX_WORDS = (LEN_W+1)'(3 * MAX_INSTR);
  localparam logic [LEN_W:0] THREE     = (LEN_W+1)'(3);
  localparam logic [LEN_W:0] ONE       = (LEN_W+1)'(1);
  localparam logic [7:0]     OP_DCL    = 8'h19;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SKIP} ld_state_t;

  ld_state_t        state;
  logic [LEN_W:0]   remain;
  logic [1:0]       slot;
  logic [31:0]      w0_q, w1_q;
  logic [CNT_W-1:0] idx;
  logic             eop_q, efld_q, smp_q;

  assign in_ready = rst_n;

  wire acc  = in_valid & in_ready;
  wire last = (remain == ONE);

  wire            hdr_ok  = (in_data[31:29] == 3'b011) && (in_data[28:24] == 5'h1D) &&
                            (in_data[23:16] == 8'h05);
  wire [LEN_W:0]  payload = {1'b0, in_data[LEN_W-1:0]} + ONE;
  wire            len_bad = ((payload % THREE) != '0) || (payload > MAX_WORDS);

  wire [7:0] op = in_data[31:24];
  wire [2:0] dt = in_data[21:19];
  wire [3:0] dn = in_data[17:14];
  wire [3:0] dm = in_data[13:10];

  wire dest_ok = (dt == 3'd0) ||
                 (((dt == 3'd4) || (dt == 3'd5)) && (dn == 4'd0)) ||
                 ((dt == 3'd6) && (dn <= 4'd2));
  wire mask_ok = (dm == 4'h1) || (dm == 4'h3) || (dm == 4'h7) || (dm == 4'h8) || (dm == 4'hF);
  wire dcl_ok  = ((dt == 3'd1) && (dn <= 4'd10) && mask_ok) ||
                 ((dt == 3'd3) && (dm == 4'h0));

  wire w0_op_bad  = op > OP_DCL;
  wire w0_fld_bad = (op < OP_DCL) ? !dest_ok : ((op == OP_DCL) ? !dcl_ok : 1'b0);
  wire w0_smp     = (op == OP_DCL) && (dt == 3'd3);
  wire smp_viol   = smp_q && (in_data != 32'h0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      remain     <= '0;
      slot       <= 2'd0;
      w0_q       <= '0;
      w1_q       <= '0;
      idx        <= '0;
      eop_q      <= 1'b0;
      efld_q     <= 1'b0;
      smp_q      <= 1'b0;
      prog_we    <= 1'b0;
      prog_addr  <= '0;
      prog_data  <= '0;
      done       <= 1'b0;
      done_count <= '0;
      err_len    <= 1'b0;
      err_opcode <= 1'b0;
      err_field  <= 1'b0;
      hdr_drop   <= 1'b0;
    end else begin
      prog_we  <= 1'b0;
      done     <= 1'b0;
      hdr_drop <= 1'b0;
      if (acc) begin
        case (state)
          ST_IDLE: begin
            if (hdr_ok) begin
              remain <= payload;
              slot   <= 2'd0;
              idx    <= '0;
              eop_q  <= 1'b0;
              efld_q <= 1'b0;
              smp_q  <= 1'b0;
              state  <= len_bad ? ST_SKIP : ST_LOAD;
            end else begin
              hdr_drop <= 1'b1;
            end
          end
          ST_LOAD: begin
            remain <= remain - ONE;
            case (slot)
              2'd0: begin
                w0_q   <= in_data;
                eop_q  <= eop_q | w0_op_bad;
                efld_q <= efld_q | w0_fld_bad;
                smp_q  <= w0_smp;
                slot   <= 2'd1;
              end
              2'd1: begin
                w1_q   <= in_data;
                efld_q <= efld_q | smp_viol;
                slot   <= 2'd2;
              end
              default: begin
                prog_we   <= 1'b1;
                prog_addr <= idx[ADDR_W-1:0];
                prog_data <= {in_data, w1_q, w0_q};
                idx       <= idx + CNT_W'(1);
                efld_q    <= efld_q | smp_viol;
                slot      <= 2'd0;
                if (last) begin
                  done       <= 1'b1;
                  done_count <= idx + CNT_W'(1);
                  err_len    <= 1'b0;
                  err_opcode <= eop_q;
                  err_field  <= efld_q | smp_viol;
                  state      <= ST_IDLE;
                end
              end
            endcase
          end
          ST_SKIP: begin
            remain <= remain - ONE;
            if (last) begin
              done       <= 1'b1;
              done_count <= '0;
              err_len    <= 1'b1;
              err_opcode <= 1'b0;
              err_field  <= 1'b0;
              state      <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/shader_loader_chk.sv
module shader_loader_chk #(
  parameter int MAX_INSTR = 123,
  parameter int ADDR_W    = 7,
  parameter int CNT_W     = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_we,
  input logic [ADDR_W-1:0] prog_addr,
  input logic              done,
  input logic [CNT_W-1:0]  done_count,
  input logic              err_len,
  input logic              err_opcode,
  input logic              err_field,
  input logic              hdr_drop
);

  AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_drop |-> !prog_we); // R2

  AST_LEN_ERR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_len) |-> (done_count == '0 && !err_opcode && !err_field)); // R3

  AST_WRITE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |=> !prog_we); // R5

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |-> (32'(prog_addr) < MAX_INSTR)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (32'(done_count) <= MAX_INSTR)); // R6

  AST_DONE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err_len) |-> prog_we); // R6

  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(done_count) && $stable(err_opcode) && $stable(err_field) &&
               $stable(err_len))); // R10

endmodule

bind shader_loader shader_loader_chk #(
  .MAX_INSTR(MAX_INSTR),
  .ADDR_W(ADDR_W),
  .CNT_W(CNT_W)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .prog_we(prog_we),
  .prog_addr(prog_addr),
  .done(done),
  .done_count(done_count),
  .err_len(err_len),
  .err_opcode(err_opcode),
  .err_field(err_field),
  .hdr_drop(hdr_drop)
);

// File: tb/test_shader_loader.sv
module test_shader_loader;
  localparam int CLK_PERIOD = 10;
  localparam int MAXI       = 123;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = 32'hDEAD_BEEF;
  logic        in_ready, prog_we, done, err_len, err_opcode, err_field, hdr_drop;
  logic [6:0]  prog_addr, done_count;
  logic [95:0] prog_data;

  shader_loader i_shader_loader (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data), .done(done),
    .done_count(done_count), .err_len(err_len), .err_opcode(err_opcode),
    .err_field(err_field), .hdr_drop(hdr_drop)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    fin = 0;
  string fld_tag = "R8";

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [95:0] act, input logic [95:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!fin) begin
      fin = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  // reference model
  int          m_mode = 0;
  int          m_left = 0;
  int          m_n = 0;
  bit          m_eop = 0, m_efld = 0;
  logic [31:0] q[$];
  logic        x_we = 0, x_done = 0, x_len = 0, x_op = 0, x_fld = 0, x_drop = 0;
  logic [6:0]  x_addr = 0, x_cnt = 0;
  logic [95:0] x_data = 0;

  function automatic void judge(input logic [31:0] a, input logic [31:0] b,
                                input logic [31:0] c, output bit ob, output bit fb);
    int o, t, n, mk;
    o = int'(a[31:24]); t = int'(a[21:19]); n = int'(a[17:14]); mk = int'(a[13:10]);
    ob = (o > 25);
    fb = 0;
    if (o < 25) begin
      if (t == 4 || t == 5) fb = (n != 0);
      else if (t == 6) fb = (n > 2);
      else if (t != 0) fb = 1;
    end else if (o == 25) begin
      if (t == 1) fb = !(n <= 10 && (mk == 1 || mk == 3 || mk == 7 || mk == 8 || mk == 15));
      else if (t == 3) fb = !(mk == 0 && b == 0 && c == 0);
      else fb = 1;
    end
  endfunction

  always @(posedge clk) begin
    bit ob, fb;
    if (!rst_n) begin
      m_mode = 0; q.delete();
      x_we = 0; x_done = 0; x_len = 0; x_op = 0; x_fld = 0; x_drop = 0;
      x_addr = 0; x_cnt = 0; x_data = 0;
    end else begin
      x_we = 0; x_done = 0; x_drop = 0;
      if (in_valid) begin
        if (m_mode == 0) begin
          if (in_data[31:16] == 16'h7D05) begin
            m_left = int'(in_data[15:0]) + 1;
            q.delete(); m_n = 0; m_eop = 0; m_efld = 0;
            m_mode = (m_left % 3 != 0 || m_left > 3 * MAXI) ? 2 : 1;
          end else x_drop = 1;
        end else if (m_mode == 1) begin
          q.push_back(in_data);
          m_left--;
          if (q.size() == 3) begin
            x_we = 1; x_addr = 7'(m_n); x_data = {q[2], q[1], q[0]};
            judge(q[0], q[1], q[2], ob, fb);
            m_eop |= ob; m_efld |= fb;
            m_n++;
            q.delete();
          end
          if (m_left == 0) begin
            x_done = 1; x_cnt = 7'(m_n); x_len = 0; x_op = m_eop; x_fld = m_efld; m_mode = 0;
          end
        end else begin
          m_left--;
          if (m_left == 0) begin
            x_done = 1; x_cnt = 0; x_len = 1; x_op = 0; x_fld = 0; m_mode = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!fin) begin
      string t4, t5, t6, t3, t7, tf, t2;
      t4 = rst_n ? "R4" : "R1"; t5 = rst_n ? "R5" : "R1"; t6 = rst_n ? "R6" : "R1";
      t3 = rst_n ? "R3" : "R1"; t7 = rst_n ? "R7" : "R1"; tf = rst_n ? fld_tag : "R1";
      t2 = rst_n ? "R2" : "R1";
      chk(in_ready === rst_n, t4, "in_ready", 96'(in_ready), 96'(rst_n));
      chk(prog_we === x_we, t5, "prog_we", 96'(prog_we), 96'(x_we));
      if (x_we || !rst_n) begin
        chk(prog_addr === x_addr, t5, "prog_addr", 96'(prog_addr), 96'(x_addr));
        chk(prog_data === x_data, t5, "prog_data", prog_data, x_data);
      end
      chk(done === x_done, t6, "done", 96'(done), 96'(x_done));
      chk(done_count === x_cnt, t6, "done_count", 96'(done_count), 96'(x_cnt));
      chk(err_len === x_len, t3, "err_len", 96'(err_len), 96'(x_len));
      chk(err_opcode === x_op, t7, "err_opcode", 96'(err_opcode), 96'(x_op));
      chk(err_field === x_fld, tf, "err_field", 96'(err_field), 96'(x_fld));
      chk(hdr_drop === x_drop, t2, "hdr_drop", 96'(hdr_drop), 96'(x_drop));
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !fin) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      finish_run();
    end
  end

  function automatic logic [31:0] mk(input int o, input int t, input int n, input int m);
    return {8'(o), 2'b00, 3'(t), 1'b0, 4'(n), 4'(m), 10'h0};
  endfunction

  function automatic logic [31:0] hdr(input int f);
    return 32'h7D05_0000 | 32'(f);
  endfunction

  task automatic put(input logic [31:0] w, input int gap);
    repeat (gap) @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 32'hDEAD_BEEF;
  endtask

  task automatic put3(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    put(a, 0); put(b, 1); put(c, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: non-matching headers
    put(32'h7D06_0005, 0);
    put(32'h5D05_0005, 1);
    put(32'h7C05_0002, 0);

    // R5: clean two-instruction packet
    put(hdr(5), 2);
    put3(mk(2, 0, 1, 15), 32'h1111_0000, 32'h2222_0000);
    put3(mk(21, 4, 0, 0) | 32'h2, 32'h0102_0000, 32'h0);
    chk(done === 1'b1 && done_count == 7'd2, "R6", "count after 2", 96'(done_count), 96'd2);

    // R7 and R8: undefined opcode, then U destination number 3
    fld_tag = "R8";
    put(hdr(5), 1);
    put3(mk(26, 0, 0, 15), 32'h1, 32'h2);
    put3(mk(3, 6, 3, 15), 32'h3, 32'h4);
    chk(err_opcode === 1'b1, "R7", "opcode flag", 96'(err_opcode), 96'd1);

    // R10: clean packet after errors clears flags and holds them
    put(hdr(2), 0);
    put3(mk(1, 6, 2, 3), 32'h5, 32'h6);
    repeat (2) @(negedge clk);
    chk(err_opcode === 1'b0 && err_field === 1'b0 && done_count == 7'd1, "R10",
        "flags cleared", 96'({err_opcode, err_field}), 96'd0);

    // R9: legal declarations
    fld_tag = "R9";
    put(hdr(8), 0);
    put3(mk(25, 1, 10, 15), 32'h0, 32'h0);
    put3(mk(25, 3, 15, 0), 32'h0, 32'h0);
    put3(mk(25, 1, 3, 8), 32'h0, 32'h0);
    chk(err_field === 1'b0, "R9", "legal dcl", 96'(err_field), 96'd0);
    // R9: illegal declarations, one per packet
    put(hdr(2), 1); put3(mk(25, 1, 8, 5), 32'h0, 32'h0);
    chk(err_field === 1'b1, "R9", "mask xz", 96'(err_field), 96'd1);
    put(hdr(2), 0); put3(mk(25, 1, 11, 1), 32'h0, 32'h0);
    put(hdr(2), 0); put3(mk(25, 3, 0, 0), 32'h0, 32'h1);
    chk(err_field === 1'b1, "R9", "sampler word3", 96'(err_field), 96'd1);
    put(hdr(2), 0); put3(mk(25, 3, 0, 1), 32'h0, 32'h0);
    put(hdr(2), 0); put3(mk(25, 0, 0, 15), 32'h0, 32'h0);
    fld_tag = "R8";
    put(hdr(2), 0); put3(mk(2, 4, 1, 15), 32'h0, 32'h0);
    chk(err_field === 1'b1, "R8", "OC nr 1", 96'(err_field), 96'd1);

    // R3: length errors (not multiple of three, single word, too long)
    put(hdr(4), 0);
    for (int i = 0; i < 5; i++) put(hdr(2), i % 2);
    chk(err_len === 1'b1 && done_count == 7'd0, "R3", "len 5", 96'(err_len), 96'd1);
    put(hdr(0), 0);
    put(32'h0, 0);
    put(hdr(371), 0);
    for (int i = 0; i < 372; i++) put(mk(2, 0, 0, 15), 0);
    chk(err_len === 1'b1, "R3", "len 372", 96'(err_len), 96'd1);

    // R6: full-size program, back to back
    fld_tag = "R8";
    put(hdr(368), 0);
    for (int i = 0; i < MAXI; i++) begin
      put(mk(2, 0, i % 16, 15), 0);
      put(32'(i), 0);
      put(~32'(i), 0);
    end
    chk(done === 1'b1 && done_count == 7'd123 && err_len === 1'b0, "R6", "count 123",
        96'(done_count), 96'd123);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule